// File: doc/BRIEF.md
# Multi-Mode Timer/Counter Pair

This block holds two timer/counter channels. Each channel has a low byte and a high byte. A small configuration field per channel picks the counting mode, the count source and gating. There are three counting modes. The first joins both bytes into one 16-bit up-counter. The second counts only the low byte and reloads it from the high byte each time the low byte overflows. The third splits channel 0 into two free 8-bit counters. When a counter overflows it raises a flag, and that flag drives the channel's interrupt output. An acknowledge pulse clears the flag, and so does a register write.

Each channel counts one of two things, chosen by its configuration. The first is a tick from an internal divider that fires once every six clock cycles. The second is falling edges on the channel's external count pin. Counting runs only while the channel's run bit is set. If gating is enabled, the channel's external gate pin must also be high. Software reaches all bytes, the configuration and the run/flag bits through a flat byte-wide register port. Register writes take effect on the clock edge. Reads are combinational.

Top module: `tmr_pair`

## Requirements
- R1: After synchronous reset, every register reads 0x00 and both `irq` outputs are 0.
- R2: Register map, by `bus_addr`:
  - 0 = channel 0 low byte; 1 = channel 0 high byte; 2 = channel 1 low byte; 3 = channel 1 high byte.
  - 4 = configuration. Bits [1:0] hold the channel 0 mode, bit 2 the channel 0 source (0 internal tick, 1 count pin) and bit 3 the channel 0 gate enable. Bits [7:4] hold the same fields for channel 1.
  - 5 = control. Bit 0 and bit 1 are the run bits of channels 0 and 1. Bit 4 and bit 5 are their flags.
  - Addresses 6 and 7 read 0x00. A written byte reads back unchanged.
- R3: The internal source advances a counting channel exactly once every 6 clock cycles, so 60 running cycles add exactly 10.
- R4: Mode 1 is a 16-bit counter with the high byte most significant. Mode 0 behaves the same way. Going from 0xFFFF to 0x0000 sets the channel flag, and the flag appears on `irq`.
- R5: Mode 2 counts only the low byte. When the low byte overflows from 0xFF, it is loaded with the high byte and the flag is set. The reload never changes the high byte, and a high byte written later is used at the next overflow.
- R6: With source 1, each falling edge of `cnt_pin` adds exactly one. Rising edges add nothing. An edge is counted on the third rising clock edge after the pin falls.
- R7: A channel counts only when its run bit is 1 and either its gate enable is 0 or its `gate_pin` is high. The gate pin is synchronized the same way as the count pin.
- R8: Mode 3 on channel 0 runs two separate counters:
  - The low byte is an 8-bit counter with channel 0's own source, gate, run bit and flag. It wraps from 0xFF to 0x00.
  - The high byte counts the internal tick whenever channel 1's run bit is 1. It ignores channel 0's pins and gate. Its wrap from 0xFF sets channel 1's flag.
- R9: While channel 0 is in mode 3, channel 1 keeps counting in its own mode but never sets its flag. Channel 1 set to mode 3 holds its value.
- R10: A one-cycle `irq_ack` bit clears that channel's flag. Writing 0 to a flag bit of the control register clears it, and writing 1 leaves it unchanged. An overflow in the same cycle as an acknowledge leaves the flag set.
- R11: A register write to a counter byte overrides that byte's increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational from `bus_addr` |
| cnt_pin | input | 2 | External count pins, one per channel |
| gate_pin | input | 2 | External gate pins, one per channel |
| irq_ack | input | 2 | Interrupt acknowledge pulses, one per channel |
| irq | output | 2 | Overflow flags, one per channel |

## Verification
The in-RTL properties watch several behaviours on every cycle:
- the mode 2 high byte stays stable across reloads;
- a stopped channel 0 low byte holds;
- the split high byte moves only on a prescaler tick with channel 1 running;
- channel 1's flag cannot rise while split mode has no high-byte wrap;
- a write lands over an increment;
- acknowledge clears;
- tick and edge pulses last a single cycle.

Other behaviours only the directed scenarios can show. These are the exact count over a 60-cycle window, the reload arithmetic, the edge counting through the synchronizer, the gate-pin effect, and flag-set winning over an acknowledge in the same edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        MODE_WIDE_ALT = 2'd0,
        MODE_WIDE     = 2'd1,
        MODE_RELOAD   = 2'd2,
        MODE_SPLIT    = 2'd3
    } mode_e;

    // Nibble layout: gate enable, source select, mode
    typedef struct packed {
        logic  gate_en;
        logic  src_ext;
        mode_e mode;
    } chan_cfg_t;

    typedef struct packed {
        byte_t lo;
        byte_t hi;
        logic  ovf;
    } cnt_res_t;

    localparam logic [2:0] ADDR_LO0 = 3'd0;
    localparam logic [2:0] ADDR_HI0 = 3'd1;
    localparam logic [2:0] ADDR_LO1 = 3'd2;
    localparam logic [2:0] ADDR_HI1 = 3'd3;
    localparam logic [2:0] ADDR_CFG = 3'd4;
    localparam logic [2:0] ADDR_CTL = 3'd5;

    localparam int CTL_FLAG_BASE = 4;

    // One step of a non-split channel; mode 3 here means "hold"
    function automatic cnt_res_t step_count(mode_e mode, byte_t lo, byte_t hi, logic inc);
        cnt_res_t r;
        logic [2*BYTE_W:0] wide;
        r.lo  = lo;
        r.hi  = hi;
        r.ovf = 1'b0;
        wide  = '0;
        if (inc) begin
            case (mode)
                MODE_RELOAD: begin
                    if (lo == '1) begin
                        r.lo  = hi;
                        r.ovf = 1'b1;
                    end else begin
                        r.lo = lo + byte_t'(1);
                    end
                end
                MODE_SPLIT: r.ovf = 1'b0;
                default: begin
                    wide = {1'b0, hi, lo} + (2*BYTE_W+1)'(1);
                    r.ovf = wide[2*BYTE_W];
                    r.hi  = wide[2*BYTE_W-1:BYTE_W];
                    r.lo  = wide[BYTE_W-1:0];
                end
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int DIV = 6
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + CW'(1);
    end

    // R3: the tick is a lone pulse, never two cycles in a row
    a_r3_tick_single: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic level,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    assign level = sync_q[STAGES-1];
    assign fall  = prev_q & ~level;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            prev_q <= level;
        end
    end

    // R6: one falling edge gives a single-cycle count enable
    a_r6_fall_single: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall);

endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
    import tmr_pkg::*;
#(
    parameter int PRESCALE    = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] bus_addr,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic [1:0] cnt_pin,
    input  logic [1:0] gate_pin,
    input  logic [1:0] irq_ack,
    output logic [1:0] irq
);
    localparam int NCH = 2;

    byte_t     [NCH-1:0] lo_q, hi_q, nxt_lo, nxt_hi;
    chan_cfg_t [NCH-1:0] cfg_q;
    logic      [NCH-1:0] run_q, flag_q, set_flag;
    logic      [NCH-1:0] wr_lo, wr_hi;
    logic      [NCH-1:0] cnt_fall, gate_lvl, inc;
    logic                tick, split, hi_inc, hi_wrap;
    logic                wr_cfg, wr_ctl;
    cnt_res_t            res [NCH];

    tmr_prescale #(.DIV(PRESCALE)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic cnt_lvl_unused;

        tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .pin   (cnt_pin[g]),
            .level (cnt_lvl_unused),
            .fall  (cnt_fall[g])
        );

        tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_gate (
            .clk   (clk),
            .rst   (rst),
            .pin   (gate_pin[g]),
            .level (gate_lvl[g]),
            .fall  ()
        );

        assign inc[g] = run_q[g]
                      & (~cfg_q[g].gate_en | gate_lvl[g])
                      & (cfg_q[g].src_ext ? cnt_fall[g] : tick);

        assign wr_lo[g] = bus_wr && (bus_addr == 3'(2 * g));
        assign wr_hi[g] = bus_wr && (bus_addr == 3'(2 * g + 1));
    end

    assign wr_cfg = bus_wr && (bus_addr == ADDR_CFG);
    assign wr_ctl = bus_wr && (bus_addr == ADDR_CTL);
    assign split  = (cfg_q[0].mode == MODE_SPLIT);
    assign hi_inc = run_q[1] & tick;

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            res[c]      = step_count(cfg_q[c].mode, lo_q[c], hi_q[c], inc[c]);
            nxt_lo[c]   = res[c].lo;
            nxt_hi[c]   = res[c].hi;
            set_flag[c] = res[c].ovf;
        end
        hi_wrap = 1'b0;
        if (split) begin
            nxt_lo[0]   = lo_q[0] + byte_t'(inc[0]);
            set_flag[0] = inc[0] && (lo_q[0] == '1);
            nxt_hi[0]   = hi_q[0] + byte_t'(hi_inc);
            hi_wrap     = hi_inc && (hi_q[0] == '1);
            set_flag[1] = hi_wrap;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q   <= '0;
            hi_q   <= '0;
            cfg_q  <= '0;
            run_q  <= '0;
            flag_q <= '0;
        end else begin
            for (int c = 0; c < NCH; c++) begin
                lo_q[c] <= wr_lo[c] ? bus_wdata : nxt_lo[c];
                hi_q[c] <= wr_hi[c] ? bus_wdata : nxt_hi[c];
                if (set_flag[c])
                    flag_q[c] <= 1'b1;
                else if (irq_ack[c])
                    flag_q[c] <= 1'b0;
                else if (wr_ctl && !bus_wdata[CTL_FLAG_BASE + c])
                    flag_q[c] <= 1'b0;
            end
            if (wr_cfg) cfg_q <= bus_wdata;
            if (wr_ctl) run_q <= bus_wdata[NCH-1:0];
        end
    end

    always_comb begin
        case (bus_addr)
            ADDR_LO0: bus_rdata = lo_q[0];
            ADDR_HI0: bus_rdata = hi_q[0];
            ADDR_LO1: bus_rdata = lo_q[1];
            ADDR_HI1: bus_rdata = hi_q[1];
            ADDR_CFG: bus_rdata = cfg_q;
            ADDR_CTL: bus_rdata = {2'b00, flag_q, 2'b00, run_q};
            default:  bus_rdata = 8'h00;
        endcase
    end

    assign irq = flag_q;

    // R5: reload mode never alters the high byte except by a write
    a_r5_reload_keeps_hi: assert property (@(posedge clk) disable iff (rst)
        (cfg_q[0].mode == MODE_RELOAD && !wr_hi[0]) |=> $stable(hi_q[0]));

    // R7: a stopped channel 0 low byte holds its value
    a_r7_stopped_holds: assert property (@(posedge clk) disable iff (rst)
        (!run_q[0] && !wr_lo[0]) |=> $stable(lo_q[0]));

    // R8: split high byte moves only on a tick with channel 1 running
    a_r8_split_hi_tick: assert property (@(posedge clk) disable iff (rst)
        (split && !wr_hi[0] && !(run_q[1] && tick)) |=> $stable(hi_q[0]));

    // R9: in split mode channel 1 cannot raise its flag on its own
    a_r9_no_ch1_flag: assert property (@(posedge clk) disable iff (rst)
        (split && !hi_wrap && !flag_q[1]) |=> !flag_q[1]);

    // R10: acknowledge clears the flag when no overflow coincides
    a_r10_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (irq_ack[0] && !set_flag[0]) |=> !irq[0]);

    // R11: written low byte wins over any increment
    a_r11_write_wins: assert property (@(posedge clk) disable iff (rst)
        wr_lo[0] |=> (lo_q[0] == $past(bus_wdata)));

endmodule

// File: tb/tmr_pair_tb.sv
`timescale 1ns/1ps
module tmr_pair_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] cnt_pin = 2'b11;
    logic [1:0] gate_pin = 2'b00;
    logic [1:0] irq_ack = 2'b00;
    logic [1:0] irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tmr_pair u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt_pin   (cnt_pin),
        .gate_pin  (gate_pin),
        .irq_ack   (irq_ack),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        bus_wr = 1'b0;
        irq_ack = 2'b00;
        cnt_pin = 2'b11;
        gate_pin = 2'b00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_wdata = d;
        bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // Run bits held for exactly 60 counting edges; flag bits written as 1 (no effect)
    task automatic run_window(input logic [1:0] runs);
        wr(3'd5, {2'b00, 2'b11, 2'b00, runs});
        repeat (58) @(negedge clk);
        wr(3'd5, 8'h30);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        do_reset();
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check("R1 reset register", v, 8'h00);
        end
        check("R1 reset irq", {6'd0, irq}, 8'h00);
    endtask

    task automatic t_regmap();
        logic [7:0] v;
        do_reset();
        wr(3'd0, 8'h5A); wr(3'd1, 8'hA5); wr(3'd2, 8'h3C); wr(3'd3, 8'hC3);
        wr(3'd4, 8'h66);
        rd(3'd0, v); check("R2 lo0", v, 8'h5A);
        rd(3'd1, v); check("R2 hi0", v, 8'hA5);
        rd(3'd2, v); check("R2 lo1", v, 8'h3C);
        rd(3'd3, v); check("R2 hi1", v, 8'hC3);
        rd(3'd4, v); check("R2 cfg", v, 8'h66);
        rd(3'd6, v); check("R2 unused", v, 8'h00);
    endtask

    task automatic t_prescale();
        logic [7:0] v;
        do_reset();
        wr(3'd4, 8'h01);
        run_window(2'b01);
        rd(3'd0, v); check("R3 ten ticks lo", v, 8'h0A);
        rd(3'd1, v); check("R3 ten ticks hi", v, 8'h00);
    endtask

    task automatic t_wide();
        logic [7:0] v;
        do_reset();
        wr(3'd4, 8'h01);
        wr(3'd0, 8'hFE); wr(3'd1, 8'hFF);
        run_window(2'b01);
        rd(3'd0, v); check("R4 wrap lo", v, 8'h08);
        rd(3'd1, v); check("R4 wrap hi", v, 8'h00);
        check("R4 flag", {6'd0, irq}, 8'h01);
        wr(3'd5, 8'h20);
        check("R10 write-0 clears", {6'd0, irq}, 8'h00);
        wr(3'd4, 8'h00);
        wr(3'd0, 8'hFF); wr(3'd1, 8'h00);
        run_window(2'b01);
        rd(3'd0, v); check("R4 mode0 lo", v, 8'h09);
        rd(3'd1, v); check("R4 mode0 hi", v, 8'h01);
    endtask

    task automatic t_reload();
        logic [7:0] v;
        do_reset();
        wr(3'd4, 8'h02);
        wr(3'd1, 8'hF0); wr(3'd0, 8'hFE);
        run_window(2'b01);
        rd(3'd0, v); check("R5 reload lo", v, 8'hF8);
        rd(3'd1, v); check("R5 hi unchanged", v, 8'hF0);
        check("R5 flag", {6'd0, irq}, 8'h01);
        @(negedge clk); irq_ack = 2'b01;
        @(negedge clk); irq_ack = 2'b00;
        check("R10 ack clears", {6'd0, irq}, 8'h00);
        wr(3'd1, 8'h80); wr(3'd0, 8'hFE);
        run_window(2'b01);
        rd(3'd0, v); check("R5 new reload value", v, 8'h88);
    endtask

    task automatic t_extpin();
        logic [7:0] v;
        do_reset();
        wr(3'd4, 8'h05);
        wr(3'd5, 8'h31);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); cnt_pin[0] = 1'b0;
            repeat (4) @(negedge clk); cnt_pin[0] = 1'b1;
            repeat (3) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        rd(3'd0, v); check("R6 five falling edges", v, 8'h05);
        wr(3'd4, 8'h0D);
        gate_pin[0] = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); cnt_pin[0] = 1'b0;
            repeat (4) @(negedge clk); cnt_pin[0] = 1'b1;
            repeat (3) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        rd(3'd0, v); check("R7 gate low blocks", v, 8'h05);
        gate_pin[0] = 1'b1;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 2; i++) begin
            @(negedge clk); cnt_pin[0] = 1'b0;
            repeat (4) @(negedge clk); cnt_pin[0] = 1'b1;
            repeat (3) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        rd(3'd0, v); check("R7 gate high counts", v, 8'h07);
    endtask

    task automatic t_split_ch1();
        logic [7:0] v;
        do_reset();
        wr(3'd4, 8'h13);
        wr(3'd0, 8'h33); wr(3'd1, 8'h00);
        wr(3'd2, 8'hFE); wr(3'd3, 8'hFF);
        run_window(2'b10);
        rd(3'd1, v); check("R8 split hi counts", v, 8'h0A);
        rd(3'd0, v); check("R8 split lo idle", v, 8'h33);
        rd(3'd2, v); check("R9 ch1 keeps counting", v, 8'h08);
        check("R9 ch1 no flag", {6'd0, irq}, 8'h00);
        wr(3'd4, 8'h31);
        wr(3'd2, 8'h44);
        run_window(2'b10);
        rd(3'd2, v); check("R9 ch1 mode3 holds", v, 8'h44);
    endtask

    task automatic t_split_gate();
        logic [7:0] v;
        do_reset();
        wr(3'd4, 8'h1B);
        wr(3'd0, 8'hFE); wr(3'd1, 8'hFE);
        run_window(2'b11);
        rd(3'd0, v); check("R8 lo gated off", v, 8'hFE);
        rd(3'd1, v); check("R8 hi ignores gate", v, 8'h08);
        check("R8 hi wrap sets ch1 flag", {6'd0, irq}, 8'h02);
        gate_pin[0] = 1'b1;
        wr(3'd5, 8'h00);
        repeat (4) @(negedge clk);
        run_window(2'b01);
        rd(3'd0, v); check("R8 lo wrap", v, 8'h08);
        rd(3'd1, v); check("R8 hi needs ch1 run", v, 8'h08);
        check("R8 lo flag", {6'd0, irq}, 8'h01);
    endtask

    task automatic t_same_cycle();
        logic [7:0] v;
        do_reset();
        wr(3'd4, 8'h05);
        wr(3'd0, 8'hFF); wr(3'd1, 8'hFF);
        wr(3'd5, 8'h31);
        repeat (3) @(negedge clk);
        cnt_pin[0] = 1'b0;
        @(negedge clk);
        @(negedge clk); irq_ack = 2'b01;
        @(negedge clk); irq_ack = 2'b00;
        check("R10 set beats ack", {6'd0, irq}, 8'h01);
        rd(3'd0, v); check("R10 counted to zero", v, 8'h00);
        cnt_pin[0] = 1'b1;
        wr(3'd0, 8'h10);
        repeat (4) @(negedge clk);
        cnt_pin[0] = 1'b0;
        @(negedge clk);
        wr(3'd0, 8'h40);
        repeat (5) @(negedge clk);
        rd(3'd0, v); check("R11 write beats increment", v, 8'h40);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_regmap();
        t_prescale();
        t_wide();
        t_reload();
        t_extpin();
        t_split_ch1();
        t_split_gate();
        t_same_cycle();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule